// File: doc/BRIEF.md
# Gated Decimal Frequency Meter

This block measures the frequency of an external signal. A free-running reference clock defines a gate of `REF_HZ` cycles, one second when `REF_HZ` equals the reference frequency. During each gate a decimal (BCD) counter counts rising edges of the measured signal, which is first brought into the reference domain through a synchroniser. When the gate closes, a one-cycle latch pulse copies the count into a display register. In the next cycle a clear pulse restarts the counter. The display register drives one seven-segment pattern per decimal digit, so the reading stays steady while the next gate is counted.

The gate sequencer has three named states. COUNT waits through `REF_HZ-2` cycles. It then takes the transition COUNT→LATCH, and the latch pulse is high for one cycle. LATCH→CLEAR follows unconditionally, and the clear pulse is high for one cycle. CLEAR→COUNT then restarts the wait. An edge that arrives while the latch pulse is high is held back and counted in the next gate. If the count would pass the largest value the digits can show, the counter stops at all nines and raises an over-range flag.

Top module: `freq_meter`

## Requirements
- R1: After reset every digit shows the pattern for 0 and `over_o` is 0, until the first gate closes.
- R2: Each rising edge of `meas_i` is counted in exactly one gate. Each gate is `REF_HZ` reference cycles long, and latch pulses are exactly `REF_HZ` cycles apart.
- R3: The latch pulse is followed in the very next cycle by the clear pulse. Each gate's reading therefore starts from zero and does not include earlier gates.
- R4: The count is decimal. Each digit runs from 0 to 9 and carries into the next more significant digit, so 9 goes to 10 and 99 goes to 100.
- R5: If a gate contains more than 10^DIGITS−1 edges, the reading is all nines and `over_o` is 1. The flag clears with the next gate whose count is in range.
- R6: `seg_o[7*i+6:7*i]` shows decimal digit i, where digit 0 is the least significant. Within each group, bit 0 is segment a and bit 6 is segment g, and the segments are active high. The patterns for 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F in hex.
- R7: `seg_o` and `over_o` change only just after a latch pulse. They hold their value for the whole of the following gate.
- R8: An input toggling every reference cycle (high for one cycle, then low for one cycle) is counted without loss.
- R9: A long high level counts only once. Only a low-to-high change is an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_i | input | 1 | Signal to be measured, asynchronous |
| seg_o | output | 7*DIGITS | Segment patterns, 7 bits per digit, bit 0 = segment a |
| over_o | output | 1 | Over-range flag of the displayed reading |

## Verification
A rising edge on `meas_i` reaches the counter three reference cycles later, after the synchroniser and the edge detect. The reading appears on `seg_o` one cycle after the latch pulse that closes the gate. The bench places each gate's pulses well inside that gate, at least eight cycles after it opens and far from its close, so this fixed latency cannot move an edge into a neighbouring gate. Each reading is then sampled in the middle of the following gate and again shortly before that gate ends. Both samples fall well after the display update and before the next one.

// File: rtl/freqm_pkg.sv
package freqm_pkg;

    typedef enum logic [1:0] {
        G_COUNT = 2'd0,
        G_LATCH = 2'd1,
        G_CLEAR = 2'd2
    } gate_state_t;

    // Segment bits: [0]=a ... [6]=g, active high; blank for non-decimal codes
    function automatic logic [6:0] bcd_to_seg(input logic [3:0] d);
        logic [6:0] s;
        case (d)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/freqm_sync_edge.sv
module freqm_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [2:0] s_q;

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= 3'b000;
        else        s_q <= {s_q[1:0], async_i};
    end

    // s_q[1] is the second synchroniser stage, s_q[2] its delayed copy
    assign rise_o = s_q[1] & ~s_q[2];
endmodule

// File: rtl/freqm_gate_fsm.sv
module freqm_gate_fsm
    import freqm_pkg::*;
#(
    parameter int unsigned REF_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic latch_o,
    output logic clear_o
);
    localparam int unsigned TW = (REF_HZ > 2) ? $clog2(REF_HZ) : 1;
    localparam logic [TW-1:0] LAST = TW'(REF_HZ - 3);

    gate_state_t state_q, state_d;
    logic [TW-1:0] tick_q;

    // state register and gate tick counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= G_COUNT;
            tick_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == G_COUNT && tick_q != LAST) tick_q <= tick_q + 1'b1;
            else                                      tick_q <= '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            G_COUNT: if (tick_q == LAST) state_d = G_LATCH;
            G_LATCH: state_d = G_CLEAR;
            G_CLEAR: state_d = G_COUNT;
            default: state_d = G_COUNT;
        endcase
    end

    // outputs
    always_comb begin
        latch_o = 1'b0;
        clear_o = 1'b0;
        unique case (state_q)
            G_LATCH: latch_o = 1'b1;
            G_CLEAR: clear_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/freqm_bcd_counter.sv
module freqm_bcd_counter #(
    parameter int unsigned DIGITS = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  inc_i,
    input  logic                  hold_i,
    input  logic                  clr_i,
    output logic [DIGITS*4-1:0]   bcd_o,
    output logic                  over_o,
    output logic                  full_o
);
    localparam int unsigned W = DIGITS * 4;
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0]    cnt_q, cnt_inc;
    logic [DIGITS:0] carry;
    logic            over_q, pend_q;

    always_comb begin
        carry[0] = 1'b1;
        cnt_inc  = cnt_q;
        for (int i = 0; i < DIGITS; i++) begin
            if (carry[i]) begin
                if (cnt_q[i*4 +: 4] == 4'd9) begin
                    cnt_inc[i*4 +: 4] = 4'd0;
                    carry[i+1]        = 1'b1;
                end else begin
                    cnt_inc[i*4 +: 4] = cnt_q[i*4 +: 4] + 4'd1;
                    carry[i+1]        = 1'b0;
                end
            end else begin
                carry[i+1] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            over_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (clr_i) begin
            cnt_q  <= (inc_i | pend_q) ? ONE : '0;
            over_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (hold_i) begin
            pend_q <= inc_i;
        end else if (inc_i) begin
            if (carry[DIGITS]) over_q <= 1'b1;
            else               cnt_q  <= cnt_inc;
        end
    end

    assign bcd_o  = cnt_q;
    assign over_o = over_q;
    assign full_o = carry[DIGITS];
endmodule

// File: rtl/freq_meter.sv
module freq_meter
    import freqm_pkg::*;
#(
    parameter int unsigned REF_HZ = 50_000_000,
    parameter int unsigned DIGITS = 7
) (
    input  logic                clk_ref,
    input  logic                rst_n,
    input  logic                meas_i,
    output logic [DIGITS*7-1:0] seg_o,
    output logic                over_o
);
    localparam int unsigned W = DIGITS * 4;

    logic         meas_edge, latch_p, clear_p;
    logic [W-1:0] cnt_bcd, disp_bcd;
    logic         cnt_ovr, cnt_full, disp_ovr;

    freqm_sync_edge u_sync (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .async_i (meas_i),
        .rise_o  (meas_edge)
    );

    freqm_gate_fsm #(.REF_HZ(REF_HZ)) u_gate (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .latch_o (latch_p),
        .clear_o (clear_p)
    );

    freqm_bcd_counter #(.DIGITS(DIGITS)) u_cnt (
        .clk    (clk_ref),
        .rst_n  (rst_n),
        .inc_i  (meas_edge),
        .hold_i (latch_p),
        .clr_i  (clear_p),
        .bcd_o  (cnt_bcd),
        .over_o (cnt_ovr),
        .full_o (cnt_full)
    );

    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            disp_bcd <= '0;
            disp_ovr <= 1'b0;
        end else if (latch_p) begin
            disp_bcd <= cnt_bcd;
            disp_ovr <= cnt_ovr;
        end
    end

    for (genvar g = 0; g < DIGITS; g++) begin : g_seg
        assign seg_o[g*7 +: 7] = bcd_to_seg(disp_bcd[g*4 +: 4]);
    end

    assign over_o = disp_ovr;
endmodule

// File: rtl/freq_meter_checker.sv
module freq_meter_checker #(
    parameter int unsigned REF_HZ = 50_000_000,
    parameter int unsigned DIGITS = 7
) (
    input logic                clk_ref,
    input logic                rst_n,
    input logic                meas_edge,
    input logic                latch_p,
    input logic                clear_p,
    input logic [DIGITS*4-1:0] cnt_bcd,
    input logic                cnt_ovr,
    input logic                cnt_full,
    input logic [DIGITS*4-1:0] disp_bcd
);
    logic [31:0] gap_q;
    logic        seen_q;

    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (latch_p) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R2: gates are exactly REF_HZ cycles apart
    a_r2_gate_period: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (latch_p && seen_q) |-> (gap_q == REF_HZ - 1));

    // R3: clear follows latch in the next cycle
    a_r3_clear_after_latch: assert property (@(posedge clk_ref) disable iff (!rst_n)
        latch_p |=> clear_p);

    a_r3_pulses_apart: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $onehot0({latch_p, clear_p}));

    a_r3_restart: assert property (@(posedge clk_ref) disable iff (!rst_n)
        clear_p |=> (cnt_bcd <= DIGITS*4'(1)) && !cnt_ovr);

    // R5: counter stops at all nines and flags over-range
    a_r5_saturate: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (meas_edge && cnt_full && !latch_p && !clear_p) |=> (cnt_ovr && $stable(cnt_bcd)));

    // R7: display only moves after a latch pulse
    a_r7_hold: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !latch_p |=> $stable(disp_bcd));
endmodule

bind freq_meter freq_meter_checker #(.REF_HZ(REF_HZ), .DIGITS(DIGITS)) u_chk (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .meas_edge (meas_edge),
    .latch_p   (latch_p),
    .clear_p   (clear_p),
    .cnt_bcd   (cnt_bcd),
    .cnt_ovr   (cnt_ovr),
    .cnt_full  (cnt_full),
    .disp_bcd  (disp_bcd)
);

// File: tb/tb_freq_meter.sv
module tb_freq_meter;
    localparam int REF    = 2304;
    localparam int DIG    = 3;
    localparam int MAXV   = 999;
    localparam int NWIN   = 9;

    logic             clk_ref = 1'b0;
    logic             rst_n   = 1'b0;
    logic             meas_i  = 1'b0;
    logic [DIG*7-1:0] seg_o;
    logic             over_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    int    exp_val[$];
    bit    exp_ovr[$];
    string exp_tag[$];

    always #2 clk_ref = ~clk_ref;

    always @(posedge clk_ref) if (rst_n) cyc <= cyc + 1;

    freq_meter #(.REF_HZ(REF), .DIGITS(DIG)) dut (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .meas_i  (meas_i),
        .seg_o   (seg_o),
        .over_o  (over_o)
    );

    function automatic logic [6:0] pat(input int d);
        case (d)
            0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
            4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
            8: return 7'h7F;  9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    function automatic logic [DIG*7-1:0] segs_of(input int v);
        logic [DIG*7-1:0] r;
        int x;
        x = v;
        for (int i = 0; i < DIG; i++) begin
            r[i*7 +: 7] = pat(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk_ref);
    endtask

    // driver: pulses for gate w, expectation pushed to scoreboard
    task automatic drive_window(input int w, input int n, input int hi, input int lo,
                                input string tag);
        wait_cyc(w * REF + 8);
        exp_val.push_back((n > MAXV) ? MAXV : n);
        exp_ovr.push_back(n > MAXV);
        exp_tag.push_back(tag);
        for (int p = 0; p < n; p++) begin
            meas_i = 1'b1;
            repeat (hi) @(negedge clk_ref);
            meas_i = 1'b0;
            repeat (lo) @(negedge clk_ref);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk_ref);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        repeat (5) @(negedge clk_ref);
        chk("R1 seg in reset", int'(seg_o), int'(segs_of(0)));
        chk("R1 over in reset", int'(over_o), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk_ref);
        chk("R1 seg after reset", int'(seg_o), int'(segs_of(0)));
        chk("R1 over after reset", int'(over_o), 0);

        fork
            begin : driver
                drive_window(0, 1,    1, 1, "R2");
                drive_window(1, 9,    1, 1, "R4");
                drive_window(2, 10,   1, 1, "R4");
                drive_window(3, 100,  2, 2, "R4");
                drive_window(4, 123,  5, 3, "R9");
                drive_window(5, 999,  1, 1, "R8");
                drive_window(6, 1000, 1, 1, "R5");
                drive_window(7, 5,    1, 1, "R5");
                drive_window(8, 0,    1, 1, "R3");
            end
            begin : monitor
                for (int w = 0; w < NWIN; w++) begin
                    int    v;
                    bit    o;
                    string t;
                    wait_cyc((w + 1) * REF + REF / 2);
                    v = exp_val.pop_front();
                    o = exp_ovr.pop_front();
                    t = exp_tag.pop_front();
                    chk($sformatf("%s R6 gate %0d reading", t, w), int'(seg_o), int'(segs_of(v)));
                    chk($sformatf("R5 gate %0d over", w), int'(over_o), int'(o));
                    wait_cyc((w + 2) * REF - 50);
                    chk($sformatf("R7 gate %0d held", w), int'(seg_o), int'(segs_of(v)));
                end
            end
        join

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule